// File: doc/BRIEF.md
# NAND Flash Host Bus Sequencer

This block sits on the host side of an asynchronous NAND flash bus. The command, address and data lines share one set of I/O wires. A local client hands it one request at a time: send a command byte, send an address byte, write a data word, or read a data word. The sequencer turns each request into a single strobe cycle on the flash pins. It drives the latch selects, the write and read strobes, chip enable and the output enable of the shared I/O lines. It counts system clocks so that every strobe phase meets a minimum time.

Two timing sets are derived from the clock period at elaboration. One is the normal set and one is a slower set for marginal parts. The `slow_mode` input picks between them for each request. The ready/busy line is synchronized into the clock domain. After a command byte, the sequencer waits a fixed settling delay before it trusts that line. The data path may be 8 or 16 bits wide. Command and address bytes always go out on the low eight lines, and the upper lines are driven to zero for those cycles.

Top module: `nand_bus_seq`

## Requirements
- R1: A command request (`req_op`=0) makes one cycle with `nf_cle`=1, `nf_ale`=0 and `nf_io_oe`=1. `nf_we_n` is low for the low phase, and `nf_io_out` holds `req_data[7:0]` with all upper bits zero. `nf_cle` and the data stay in place through the high phase that follows.
- R2: An address request (`req_op`=1) makes the same kind of cycle with `nf_ale`=1 and `nf_cle`=0, using the byte zero-extended in the same way.
- R3: A write request (`req_op`=2) drives the full `req_data` word with both latch selects low.
- R4: A read request (`req_op`=3) keeps `nf_io_oe` low and pulses `nf_re_n` low. At the edge that ends the low phase it stores `nf_io_in` into `rd_data` and raises `rd_valid` for exactly one cycle. Back-to-back reads return successive device words.
- R5: Every phase length is ceil(ns/CLK_NS) clocks, with a minimum of 1. The high phase is the larger of the hold time and (cycle time minus low phase). The read low phase is the larger of the pulse width and the access time. Normal set: write 25/15/45 ns, read 25/15/50 ns, access 30 ns. With CLK_NS=10 this gives 3 low clocks and 2 high clocks for both writes and reads.
- R6: With `slow_mode`=1 at acceptance, the request uses 40 ns low, 20 ns high, a 60 ns cycle and a 40 ns access time. With CLK_NS=10 this gives 4 low clocks and 2 high clocks.
- R7: `nf_rb_n` passes through two flops. `req_ready` stays low while the synchronized line is low, and no strobe cycle starts then.
- R8: After a command cycle, `req_ready` stays low for BUSY_DLY extra clocks. Address, write and read cycles add no delay. From acceptance, a command occupies low+high+BUSY_DLY clocks and any other request occupies low+high clocks.
- R9: `nf_ce_n` is low during every strobe cycle, and also whenever `chip_sel`=1, one clock after `chip_sel` changes.
- R10: During reset, `nf_ce_n`, `nf_we_n` and `nf_re_n` are 1. `nf_cle`, `nf_ale`, `nf_io_oe`, `rd_valid` and `req_ready` are 0.
- R11: `nf_cle` and `nf_ale` are never high together, and `nf_we_n` and `nf_re_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 command, 1 address, 2 write, 3 read |
| req_data | input | DW | Byte or word to send |
| req_ready | output | 1 | Request accepted this clock when valid |
| slow_mode | input | 1 | Selects the slow timing set |
| chip_sel | input | 1 | Holds chip enable active while idle |
| rd_data | output | DW | Last word read |
| rd_valid | output | 1 | One-clock pulse on new read data |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_cle | output | 1 | Command latch select |
| nf_ale | output | 1 | Address latch select |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_rb_n | input | 1 | Ready/busy from device, low = busy |
| nf_io_in | input | DW | Shared I/O lines as seen by the host |
| nf_io_out | output | DW | Value driven on the shared I/O lines |
| nf_io_oe | output | 1 | Host drives the I/O lines when 1 |

## Verification
The bench builds the block with DW=16, CLK_NS=10 and BUSY_DLY=3. At that clock period the normal and slow sets give different low-phase counts (3 against 4), so the mode switch shows directly in the measured pulse widths and cycle occupancy. The 16-bit width makes the zero upper byte of command and address cycles observable next to full-width data. The short settling delay lets the bench measure the extra command occupancy exactly, and also hold ready/busy low across and beyond that window.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

  localparam int CNT_W = 8;

  typedef enum logic [1:0] {
    OP_CMD  = 2'd0,
    OP_ADDR = 2'd1,
    OP_WR   = 2'd2,
    OP_RD   = 2'd3
  } nbs_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2
  } nbs_st_e;

  typedef struct packed {
    logic [CNT_W-1:0] wlo;
    logic [CNT_W-1:0] whi;
    logic [CNT_W-1:0] rlo;
    logic [CNT_W-1:0] rhi;
  } nbs_tim_t;

  // index 0: normal set, index 1: slow set (all in ns)
  localparam int WR_LO_NS [2] = '{25, 40};
  localparam int WR_HI_NS [2] = '{15, 20};
  localparam int WR_CY_NS [2] = '{45, 60};
  localparam int RD_LO_NS [2] = '{25, 40};
  localparam int RD_HI_NS [2] = '{15, 20};
  localparam int RD_CY_NS [2] = '{50, 60};
  localparam int RD_AC_NS [2] = '{30, 40};

  function automatic int ns_to_clk(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int high_clk(input int cy_ns, input int lo_clk,
                                  input int hi_ns, input int clk_ns);
    return max2(ns_to_clk(hi_ns, clk_ns), ns_to_clk(cy_ns, clk_ns) - lo_clk);
  endfunction

endpackage

// File: rtl/nbs_timing.sv
module nbs_timing
  import nbs_pkg::*;
#(
  parameter int CLK_NS = 20
) (
  input  logic     slow_i,
  output nbs_tim_t tim_o
);

  nbs_tim_t sets [2];

  for (genvar g = 0; g < 2; g++) begin : g_set
    localparam int WLO = ns_to_clk(WR_LO_NS[g], CLK_NS);
    localparam int RLO = max2(ns_to_clk(RD_LO_NS[g], CLK_NS),
                              ns_to_clk(RD_AC_NS[g], CLK_NS));
    localparam int WHI = high_clk(WR_CY_NS[g], WLO, WR_HI_NS[g], CLK_NS);
    localparam int RHI = high_clk(RD_CY_NS[g], RLO, RD_HI_NS[g], CLK_NS);
    assign sets[g].wlo = CNT_W'(WLO);
    assign sets[g].whi = CNT_W'(WHI);
    assign sets[g].rlo = CNT_W'(RLO);
    assign sets[g].rhi = CNT_W'(RHI);
  end

  assign tim_o = slow_i ? sets[1] : sets[0];

endmodule

// File: rtl/nbs_phase_ctr.sv
module nbs_phase_ctr
  import nbs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q, cnt_nx;

  always_comb begin
    cnt_nx = cnt_q;
    if (load_i)             cnt_nx = val_i;
    else if (cnt_q != '0)   cnt_nx = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/nbs_rb_sync.sv
module nbs_rb_sync #(
  parameter int BUSY_DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_n_i,
  input  logic arm_i,
  output logic rb_s_o,
  output logic ok_o
);

  localparam int DCW = (BUSY_DLY < 1) ? 1 : $clog2(BUSY_DLY + 1);

  logic           s1_q, s2_q;
  logic [DCW-1:0] dly_q, dly_nx;

  always_comb begin
    dly_nx = dly_q;
    if (arm_i)             dly_nx = DCW'(BUSY_DLY);
    else if (dly_q != '0)  dly_nx = dly_q - DCW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      dly_q <= '0;
    end else begin
      s1_q  <= rb_n_i;
      s2_q  <= s1_q;
      dly_q <= dly_nx;
    end
  end

  assign rb_s_o = s2_q;
  assign ok_o   = s2_q && (dly_q == '0);

endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
  import nbs_pkg::*;
#(
  parameter int DW       = 8,
  parameter int CLK_NS   = 20,
  parameter int BUSY_DLY = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [DW-1:0] req_data,
  output logic          req_ready,
  input  logic          slow_mode,
  input  logic          chip_sel,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          nf_ce_n,
  output logic          nf_cle,
  output logic          nf_ale,
  output logic          nf_we_n,
  output logic          nf_re_n,
  input  logic          nf_rb_n,
  input  logic [DW-1:0] nf_io_in,
  output logic [DW-1:0] nf_io_out,
  output logic          nf_io_oe
);

  nbs_st_e          st_q, st_nx;
  nbs_op_e          op_q, op_nx, op_in;
  logic             mode_q, mode_nx, mode_sel;
  nbs_tim_t         tim;
  logic             ctr_ld, ctr_done;
  logic [CNT_W-1:0] ctr_val;
  logic             arm, rb_ok, rb_sync, accept;
  logic             ce_nx, cle_nx, ale_nx, we_nx, re_nx, oe_nx, rdv_nx;
  logic [DW-1:0]    dout_nx, rd_nx, byte_ext;

  assign op_in    = nbs_op_e'(req_op);
  assign byte_ext = DW'(req_data[7:0]);
  assign mode_sel = (st_q == ST_IDLE) ? slow_mode : mode_q;
  assign req_ready = (st_q == ST_IDLE) && rb_ok;
  assign accept   = req_valid && req_ready;

  nbs_timing #(.CLK_NS(CLK_NS)) i_timing (
    .slow_i (mode_sel),
    .tim_o  (tim)
  );

  nbs_phase_ctr i_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (ctr_ld),
    .val_i  (ctr_val),
    .done_o (ctr_done)
  );

  nbs_rb_sync #(.BUSY_DLY(BUSY_DLY)) i_rb (
    .clk    (clk),
    .rst_n  (rst_n),
    .rb_n_i (nf_rb_n),
    .arm_i  (arm),
    .rb_s_o (rb_sync),
    .ok_o   (rb_ok)
  );

  always_comb begin
    st_nx   = st_q;
    op_nx   = op_q;
    mode_nx = mode_q;
    cle_nx  = nf_cle;
    ale_nx  = nf_ale;
    we_nx   = nf_we_n;
    re_nx   = nf_re_n;
    oe_nx   = nf_io_oe;
    dout_nx = nf_io_out;
    rd_nx   = rd_data;
    rdv_nx  = 1'b0;
    ctr_ld  = 1'b0;
    ctr_val = '0;
    arm     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_nx   = ST_LO;
          op_nx   = op_in;
          mode_nx = slow_mode;
          ctr_ld  = 1'b1;
          ctr_val = (op_in == OP_RD) ? tim.rlo - CNT_W'(1)
                                     : tim.wlo - CNT_W'(1);
          cle_nx  = (op_in == OP_CMD);
          ale_nx  = (op_in == OP_ADDR);
          oe_nx   = (op_in != OP_RD);
          we_nx   = (op_in == OP_RD);
          re_nx   = (op_in != OP_RD);
          dout_nx = (op_in == OP_WR) ? req_data : byte_ext;
        end
      end
      ST_LO: begin
        if (ctr_done) begin
          st_nx   = ST_HI;
          ctr_ld  = 1'b1;
          ctr_val = (op_q == OP_RD) ? tim.rhi - CNT_W'(1)
                                    : tim.whi - CNT_W'(1);
          we_nx   = 1'b1;
          re_nx   = 1'b1;
          if (op_q == OP_RD) begin
            rd_nx  = nf_io_in;
            rdv_nx = 1'b1;
          end
        end
      end
      ST_HI: begin
        if (ctr_done) begin
          st_nx  = ST_IDLE;
          cle_nx = 1'b0;
          ale_nx = 1'b0;
          oe_nx  = 1'b0;
          arm    = (op_q == OP_CMD);
        end
      end
      default: st_nx = ST_IDLE;
    endcase
    ce_nx = ~(chip_sel || (st_nx != ST_IDLE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      op_q      <= OP_CMD;
      mode_q    <= 1'b0;
      nf_ce_n   <= 1'b1;
      nf_cle    <= 1'b0;
      nf_ale    <= 1'b0;
      nf_we_n   <= 1'b1;
      nf_re_n   <= 1'b1;
      nf_io_oe  <= 1'b0;
      nf_io_out <= '0;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
    end else begin
      st_q      <= st_nx;
      op_q      <= op_nx;
      mode_q    <= mode_nx;
      nf_ce_n   <= ce_nx;
      nf_cle    <= cle_nx;
      nf_ale    <= ale_nx;
      nf_we_n   <= we_nx;
      nf_re_n   <= re_nx;
      nf_io_oe  <= oe_nx;
      nf_io_out <= dout_nx;
      rd_data   <= rd_nx;
      rd_valid  <= rdv_nx;
    end
  end

endmodule

// File: rtl/nbs_chk.sv
module nbs_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          nf_ce_n,
  input logic          nf_cle,
  input logic          nf_ale,
  input logic          nf_we_n,
  input logic          nf_re_n,
  input logic          nf_io_oe,
  input logic [DW-1:0] nf_io_out,
  input logic          rb_sync
);

  p_rd_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !nf_re_n |-> !nf_io_oe);

  p_latch_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nf_cle, nf_ale}));

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nf_we_n && !nf_re_n));

  p_ce_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!nf_we_n || !nf_re_n) |-> !nf_ce_n);

  p_no_start_busy_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nf_we_n) |-> $past(rb_sync));

  p_no_start_busy_re_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nf_re_n) |-> $past(rb_sync));

  p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!nf_we_n && $past(!nf_we_n)) |-> $stable(nf_io_out));

  if (DW > 8) begin : g_wide
    p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ((nf_cle || nf_ale) && nf_io_oe) |-> (nf_io_out[DW-1:8] == '0));
  end

endmodule

bind nand_bus_seq nbs_chk #(.DW(DW)) i_nbs_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .nf_ce_n   (nf_ce_n),
  .nf_cle    (nf_cle),
  .nf_ale    (nf_ale),
  .nf_we_n   (nf_we_n),
  .nf_re_n   (nf_re_n),
  .nf_io_oe  (nf_io_oe),
  .nf_io_out (nf_io_out),
  .rb_sync   (rb_sync)
);

// File: tb/test_nand_bus_seq.sv
module test_nand_bus_seq;

  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, slow_mode, chip_sel;
  logic [1:0]    req_op;
  logic [DW-1:0] req_data, rd_data, io_in, io_out;
  logic          rd_valid, ce_n, cle, ale, we_n, re_n, rb_n, io_oe;

  int checks = 0;
  int bad    = 0;
  logic [15:0] col = 16'd0;

  // monitor state
  int w_run = 0, r_run = 0, wlo_len = 0, rlo_len = 0;
  logic [DW-1:0] lat_io;
  logic lat_cle, lat_ale, lat_oe;
  int oe_viol = 0, ce_viol = 0, excl_viol = 0, rd_cnt = 0;
  logic [DW-1:0] last_rd;

  always #10 clk = ~clk;

  assign io_in = 16'hC300 + col;
  always @(negedge re_n) col <= col + 16'd1;

  nand_bus_seq #(.DW(DW), .CLK_NS(10), .BUSY_DLY(3)) i_nand_bus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_data(req_data), .req_ready(req_ready), .slow_mode(slow_mode),
    .chip_sel(chip_sel), .rd_data(rd_data), .rd_valid(rd_valid),
    .nf_ce_n(ce_n), .nf_cle(cle), .nf_ale(ale), .nf_we_n(we_n),
    .nf_re_n(re_n), .nf_rb_n(rb_n), .nf_io_in(io_in), .nf_io_out(io_out),
    .nf_io_oe(io_oe)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (!we_n) begin
        w_run++;
        lat_io = io_out; lat_cle = cle; lat_ale = ale; lat_oe = io_oe;
      end else if (w_run != 0) begin
        wlo_len = w_run; w_run = 0;
      end
      if (!re_n) begin
        r_run++;
        if (io_oe) oe_viol++;
      end else if (r_run != 0) begin
        rlo_len = r_run; r_run = 0;
      end
      if ((!we_n || !re_n) && ce_n) ce_viol++;
      if ((cle && ale) || (!we_n && !re_n)) excl_viol++;
      if (rd_valid) begin
        rd_cnt++; last_rd = rd_data;
      end
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] op, input logic [15:0] d, output int busy);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = op; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0;
    while (!req_ready) begin
      busy++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_data = '0;
    slow_mode = 1'b0; chip_sel = 1'b0; rb_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(we_n && re_n, "R10 strobes", {we_n, re_n}, 2'b11);
    chk(ce_n, "R10 ce_n", ce_n, 1);
    chk(!cle && !ale, "R10 latches", {cle, ale}, 0);
    chk(!io_oe, "R10 io_oe", io_oe, 0);
    chk(!rd_valid, "R10 rd_valid", rd_valid, 0);
    chk(!req_ready, "R10 req_ready", req_ready, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_cmd;
    int busy;
    do_op(2'd0, 16'hFF70, busy);
    chk(lat_io == 16'h0070, "R1 cmd byte", lat_io, 16'h0070);
    chk(lat_cle && !lat_ale && lat_oe, "R1 cmd latch", {lat_cle, lat_ale, lat_oe}, 3'b101);
    chk(wlo_len == 3, "R5 write low", wlo_len, 3);
    chk(busy == 8, "R8 cmd occupancy", busy, 8);
  endtask

  task automatic t_addr;
    int busy;
    do_op(2'd1, 16'h12AB, busy);
    chk(lat_io == 16'h00AB, "R2 addr byte", lat_io, 16'h00AB);
    chk(!lat_cle && lat_ale, "R2 addr latch", {lat_cle, lat_ale}, 2'b01);
    chk(busy == 5, "R8 addr no delay", busy, 5);
  endtask

  task automatic t_write;
    int busy;
    do_op(2'd2, 16'hBEEF, busy);
    chk(lat_io == 16'hBEEF, "R3 write word", lat_io, 16'hBEEF);
    chk(!lat_cle && !lat_ale && lat_oe, "R3 write latch", {lat_cle, lat_ale, lat_oe}, 3'b001);
    chk(busy == 5, "R5 write cycle", busy, 5);
  endtask

  task automatic t_read;
    int busy, n0;
    logic [15:0] c0;
    n0 = rd_cnt; c0 = col;
    do_op(2'd3, 16'h0, busy);
    chk(last_rd == 16'hC300 + c0 + 16'd1, "R4 read word 1", last_rd, 16'hC300 + c0 + 16'd1);
    chk(rlo_len == 3, "R5 read low", rlo_len, 3);
    chk(busy == 5, "R5 read cycle", busy, 5);
    do_op(2'd3, 16'h0, busy);
    chk(last_rd == 16'hC300 + c0 + 16'd2, "R4 read word 2", last_rd, 16'hC300 + c0 + 16'd2);
    chk(rd_cnt == n0 + 2, "R4 rd_valid pulses", rd_cnt, n0 + 2);
    chk(oe_viol == 0, "R4 bus released", oe_viol, 0);
  endtask

  task automatic t_slow;
    int busy;
    slow_mode = 1'b1;
    do_op(2'd0, 16'h0060, busy);
    chk(wlo_len == 4, "R6 slow write low", wlo_len, 4);
    chk(busy == 9, "R6 slow cmd occupancy", busy, 9);
    do_op(2'd3, 16'h0, busy);
    chk(rlo_len == 4, "R6 slow read low", rlo_len, 4);
    chk(busy == 6, "R6 slow read cycle", busy, 6);
    slow_mode = 1'b0;
  endtask

  task automatic t_busy;
    int lows, busy;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = 2'd0; req_data = 16'h0010; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; rb_n = 1'b0;
    req_op = 2'd2; req_data = 16'h5A5A; req_valid = 1'b1;
    lows = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!req_ready && we_n) lows++;
    end
    chk(lows >= 16, "R7 held off while busy", lows, 16);
    req_valid = 1'b0;
    rb_n = 1'b1;
    @(negedge clk);
    chk(!req_ready, "R7 sync latency", req_ready, 0);
    @(negedge clk);
    chk(req_ready, "R7 ready after sync", req_ready, 1);
    do_op(2'd2, 16'h1234, busy);
    chk(lat_io == 16'h1234, "R7 cycle after busy", lat_io, 16'h1234);
  endtask

  task automatic t_cs;
    @(negedge clk);
    chip_sel = 1'b1;
    @(negedge clk);
    chk(!ce_n, "R9 chip_sel low", ce_n, 0);
    chip_sel = 1'b0;
    @(negedge clk);
    chk(ce_n, "R9 chip_sel release", ce_n, 1);
    chk(ce_viol == 0, "R9 ce during cycles", ce_viol, 0);
    chk(excl_viol == 0, "R11 exclusive strobes", excl_viol, 0);
  endtask

  initial begin
    t_reset;
    t_cmd;
    t_addr;
    t_write;
    t_read;
    t_slow;
    t_busy;
    t_cs;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule